// File: doc/BRIEF.md
# Program Counter with Deferred High-Byte Load

This block holds the 16-bit fetch address of a small Harvard-style processor whose instructions are 12 bits wide. They carry only an 8-bit operand. The lower byte of the address can be written directly by an instruction. The upper byte cannot be written at once. An instruction stages a value for it, and that staged value is written together with the next lower-byte write. A far jump therefore lands in one step, with no half-updated address in between. The register never needs to be wider than one operand per instruction.

Each cycle in which `adv_en` is high counts as one executed instruction. The 3-bit `op_class` input tells the counter what kind of instruction it is:

- It can stage an upper byte.
- It can load the lower byte unconditionally.
- It can make a conditional jump whose target comes from the instruction immediate.
- It can make a conditional jump whose target comes from a data-memory byte.
- Any other class simply steps to the next address.

A conditional jump is taken when the carry flag is clear or the zero flag is set. Internally, a two-state machine tracks the staged upper byte:

- `HI_IDLE`: nothing is staged.
- `HI_ARMED`: an upper byte is staged and waits for the next lower-byte write.

The machine has four transitions:

- `T_STAGE`: a stage instruction moves it from `HI_IDLE` to `HI_ARMED`.
- `T_RESTAGE`: a stage instruction in `HI_ARMED` stays there and replaces the staged value.
- `T_APPLY`: a lower-byte write in `HI_ARMED` returns it to `HI_IDLE`.
- `T_HOLD`: anything else leaves the state unchanged.

Top module: `pc_seq_top`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` is 0x0000 and no upper byte is staged. A staging done before reset is therefore lost: the first lower-byte write after reset leaves the upper byte at 0x00.
- R2: When `adv_en` is high and no lower-byte write takes place, `fetch_addr` increases by 1 at the clock edge. It wraps from 0xFFFF to 0x0000. This applies to `op_class` 0 (step), to 5 to 7 (treated as step), to 1 (stage) and to a conditional jump that is not taken.
- R3: When `adv_en` is low, `fetch_addr` holds its value. `op_class` and all other inputs are ignored, including a stage request.
- R4: With `op_class` 2 (unconditional low load), `fetch_addr[7:0]` becomes `imm_val`.
- R5: `op_class` 3 and 4 are conditional jumps. They are taken exactly when `carry_in` is 0 or `zero_in` is 1.
- R6: A taken jump with `op_class` 3 writes `imm_val` into `fetch_addr[7:0]`. A taken jump with `op_class` 4 writes `mem_byte` into `fetch_addr[7:0]`.
- R7: `op_class` 1 stages `imm_val` as the next upper byte. `fetch_addr[15:8]` is not changed by the staging itself.
- R8: The staged byte is written into `fetch_addr[15:8]` in the same edge as the next lower-byte write (R4 or a taken jump). After that write, nothing remains staged.
- R9: A conditional jump that is not taken leaves the staged byte pending and unchanged.
- R10: A lower-byte write with nothing staged keeps the current `fetch_addr[15:8]`.
- R11: A second stage before any lower-byte write replaces the staged value. Only the latest one is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_en | input | 1 | One instruction executes this cycle |
| op_class | input | 3 | 0 step, 1 stage upper byte, 2 low load, 3 jump from immediate, 4 jump from memory, 5-7 step |
| imm_val | input | 8 | Instruction immediate (low target or staged upper byte) |
| mem_byte | input | 8 | Data-memory byte used as the target of `op_class` 4 |
| carry_in | input | 1 | Carry flag |
| zero_in | input | 1 | Zero flag |
| fetch_addr | output | 16 | Current program counter / fetch address |

## Verification
Every result of this block, whether a step, a load, a staging or a jump decision, is visible on `fetch_addr` exactly one rising edge after the inputs that cause it. The effect of a staging shows up only at the edge of the later lower-byte write. The bench changes inputs on a falling edge and compares `fetch_addr` on the following falling edge, one edge after the rising edge that acts on them. It checks staged-byte behaviour through the address that results from a later load. All 256 stage/load byte pairs are swept. All four flag combinations are covered for both jump sources, with and without a staged byte. A long pseudo-random instruction stream is checked against an arithmetic model.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    localparam int OP_W = 3;

    localparam logic [OP_W-1:0] OPC_STEP     = 3'd0;
    localparam logic [OP_W-1:0] OPC_STAGE_HI = 3'd1;
    localparam logic [OP_W-1:0] OPC_LOAD_LO  = 3'd2;
    localparam logic [OP_W-1:0] OPC_JUMP_IMM = 3'd3;
    localparam logic [OP_W-1:0] OPC_JUMP_MEM = 3'd4;

    typedef enum logic {
        HI_IDLE  = 1'b0,
        HI_ARMED = 1'b1
    } hi_state_e;

    typedef struct packed {
        logic stage;
        logic load_lo;
        logic jump;
        logic from_mem;
    } op_dec_t;

    function automatic op_dec_t decode_op(input logic [OP_W-1:0] opc);
        op_dec_t d;
        d = '0;
        unique case (opc)
            OPC_STAGE_HI: d.stage   = 1'b1;
            OPC_LOAD_LO:  d.load_lo = 1'b1;
            OPC_JUMP_IMM: d.jump    = 1'b1;
            OPC_JUMP_MEM: begin
                d.jump     = 1'b1;
                d.from_mem = 1'b1;
            end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pc_jump_cond.sv
module pc_jump_cond (
    input  logic carry_in,
    input  logic zero_in,
    input  logic is_jump,
    output logic taken
);
    always_comb begin
        taken = is_jump && (!carry_in || zero_in);
    end

    // R5: a jump with carry clear is always taken
    always_comb begin
        if (is_jump && !carry_in) begin
            a_nocarry_taken_r5: assert (taken);
        end
    end
endmodule

// File: rtl/pc_hi_stager.sv
module pc_hi_stager #(
    parameter int HI_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stage_req,
    input  logic            apply_req,
    input  logic [HI_W-1:0] stage_val,
    output logic            pending,
    output logic [HI_W-1:0] hi_val
);
    import pc_seq_pkg::*;

    hi_state_e       state_q, state_d;
    logic [HI_W-1:0] hold_q, hold_d;

    // next-state: T_STAGE, T_RESTAGE, T_APPLY, T_HOLD
    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        unique case (state_q)
            HI_IDLE: begin
                if (stage_req) begin
                    state_d = HI_ARMED;
                    hold_d  = stage_val;
                end
            end
            HI_ARMED: begin
                if (stage_req) begin
                    hold_d = stage_val;
                end else if (apply_req) begin
                    state_d = HI_IDLE;
                end
            end
            default: state_d = HI_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HI_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
        end
    end

    always_comb begin
        pending = (state_q == HI_ARMED);
        hi_val  = hold_q;
    end

    p_stage_arms_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stage_req |=> (pending && hi_val == $past(stage_val)));

    p_apply_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_req && !stage_req) |=> !pending);

    p_idle_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!stage_req && !apply_req) |=> ($stable(pending) && $stable(hi_val)));
endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel #(
    parameter int BYTE_W = 8,
    localparam int PC_W  = 2 * BYTE_W
) (
    input  logic [PC_W-1:0]   cur_pc,
    input  logic              load_lo,
    input  logic [BYTE_W-1:0] lo_target,
    input  logic              hi_pending,
    input  logic [BYTE_W-1:0] hi_staged,
    output logic [PC_W-1:0]   next_pc
);
    logic [BYTE_W-1:0] hi_sel;

    always_comb begin
        hi_sel = hi_pending ? hi_staged : cur_pc[PC_W-1:BYTE_W];
        if (load_lo) begin
            next_pc = {hi_sel, lo_target};
        end else begin
            next_pc = cur_pc + PC_W'(1);
        end
    end

    // R10: no staged byte means the upper byte survives a low write
    always_comb begin
        if (load_lo && !hi_pending) begin
            a_keep_hi_r10: assert (next_pc[PC_W-1:BYTE_W] == cur_pc[PC_W-1:BYTE_W]);
        end
    end
endmodule

// File: rtl/pc_seq_top.sv
module pc_seq_top #(
    parameter int BYTE_W = 8,
    localparam int PC_W  = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_en,
    input  logic [2:0]        op_class,
    input  logic [BYTE_W-1:0] imm_val,
    input  logic [BYTE_W-1:0] mem_byte,
    input  logic              carry_in,
    input  logic              zero_in,
    output logic [PC_W-1:0]   fetch_addr
);
    import pc_seq_pkg::*;

    op_dec_t           dec;
    logic              jump_taken;
    logic              lo_write;
    logic              stage_fire;
    logic [BYTE_W-1:0] lo_target;
    logic              hi_pending;
    logic [BYTE_W-1:0] hi_staged;
    logic [PC_W-1:0]   pc_q, pc_d;

    always_comb begin
        dec        = decode_op(op_class);
        lo_target  = dec.from_mem ? mem_byte : imm_val;
        lo_write   = adv_en && (dec.load_lo || jump_taken);
        stage_fire = adv_en && dec.stage;
    end

    pc_jump_cond u_cond (
        .carry_in (carry_in),
        .zero_in  (zero_in),
        .is_jump  (dec.jump),
        .taken    (jump_taken)
    );

    pc_hi_stager #(.HI_W(BYTE_W)) u_stager (
        .clk       (clk),
        .rst_n     (rst_n),
        .stage_req (stage_fire),
        .apply_req (lo_write),
        .stage_val (imm_val),
        .pending   (hi_pending),
        .hi_val    (hi_staged)
    );

    pc_next_sel #(.BYTE_W(BYTE_W)) u_next (
        .cur_pc     (pc_q),
        .load_lo    (lo_write),
        .lo_target  (lo_target),
        .hi_pending (hi_pending),
        .hi_staged  (hi_staged),
        .next_pc    (pc_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (adv_en) begin
            pc_q <= pc_d;
        end
    end

    assign fetch_addr = pc_q;

    p_step_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !lo_write) |=> fetch_addr == $past(fetch_addr) + PC_W'(1));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_en |=> $stable(fetch_addr));

    p_load_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && op_class == OPC_LOAD_LO) |=> fetch_addr[BYTE_W-1:0] == $past(imm_val));

    p_mem_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && op_class == OPC_JUMP_MEM && (!carry_in || zero_in))
            |=> fetch_addr[BYTE_W-1:0] == $past(mem_byte));

    p_apply_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_write && hi_pending) |=> fetch_addr[PC_W-1:BYTE_W] == $past(hi_staged));
endmodule

// File: tb/test_pc_seq_top.sv
module test_pc_seq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_en = 1'b0;
    logic [2:0]  op_class = 3'd0;
    logic [7:0]  imm_val = 8'd0;
    logic [7:0]  mem_byte = 8'd0;
    logic        carry_in = 1'b0;
    logic        zero_in = 1'b0;
    logic [15:0] fetch_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] exp_pc = 16'h0000;
    logic        exp_pend = 1'b0;
    logic [7:0]  exp_stg = 8'h00;

    always #4 clk = ~clk;

    pc_seq_top i_pc_seq_top (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .op_class(op_class),
        .imm_val(imm_val), .mem_byte(mem_byte), .carry_in(carry_in),
        .zero_in(zero_in), .fetch_addr(fetch_addr)
    );

    task automatic check_pc(input string req);
        checks++;
        if (fetch_addr !== exp_pc) begin
            errors++;
            $display("FAIL %s: fetch_addr=%h expected=%h", req, fetch_addr, exp_pc);
        end
    endtask

    task automatic model_step(input logic [2:0] op, input logic [7:0] imm,
                              input logic [7:0] mem, input logic c, input logic z,
                              input logic en);
        logic taken;
        logic [7:0] hi;
        if (en) begin
            taken = (op == 3'd3 || op == 3'd4) && (!c || z);
            if (op == 3'd2 || taken) begin
                hi = exp_pend ? exp_stg : exp_pc[15:8];
                exp_pc = {hi, (op == 3'd4) ? mem : imm};
                exp_pend = 1'b0;
            end else begin
                if (op == 3'd1) begin
                    exp_pend = 1'b1;
                    exp_stg = imm;
                end
                exp_pc = exp_pc + 16'd1;
            end
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [7:0] imm,
                          input logic [7:0] mem, input logic c, input logic z,
                          input logic en, input string req);
        @(negedge clk);
        op_class = op; imm_val = imm; mem_byte = mem;
        carry_in = c; zero_in = z; adv_en = en;
        model_step(op, imm, mem, c, z, en);
        @(negedge clk);
        adv_en = 1'b0;
        check_pc(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; adv_en = 1'b0;
        exp_pc = 16'h0000; exp_pend = 1'b0; exp_stg = 8'h00;
        @(negedge clk);
        check_pc("R1 reset value");
        rst_n = 1'b1;
    endtask

    initial begin
        logic [15:0] lfsr;
        logic [2:0]  rop;
        do_reset();

        // R1: staging is lost across reset
        run_op(3'd1, 8'hAB, 8'h00, 1'b0, 1'b0, 1'b1, "R7 stage does not move high byte");
        do_reset();
        run_op(3'd2, 8'h34, 8'h00, 1'b0, 1'b0, 1'b1, "R1 no stale staged byte after reset");

        // R2: plain stepping, including classes 5..7
        for (int k = 0; k < 8; k++) begin
            run_op(3'(k == 0 ? 0 : 5 + (k % 3)), 8'hFF, 8'hEE, 1'b1, 1'b0, 1'b1, "R2 step by one");
        end

        // R2: wrap from 0xFFFF
        run_op(3'd1, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, "R7 stage FF");
        run_op(3'd2, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, "R8 far load to FFFF");
        run_op(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, "R2 wrap to 0000");

        // R3: disabled cycles hold and ignore a stage request
        run_op(3'd1, 8'h5A, 8'h00, 1'b0, 1'b0, 1'b0, "R3 hold with stage while disabled");
        run_op(3'd2, 8'h77, 8'h00, 1'b0, 1'b0, 1'b0, "R3 hold with load while disabled");
        run_op(3'd2, 8'h10, 8'h00, 1'b0, 1'b0, 1'b1, "R3 ignored stage left high byte alone");

        // R4/R7/R8: sweep every staged byte with a paired low byte
        for (int v = 0; v < 256; v++) begin
            run_op(3'd1, 8'(v), 8'h00, 1'b1, 1'b0, 1'b1, "R7 stage increments only");
            run_op(3'd2, 8'(255 - v), 8'h00, 1'b1, 1'b0, 1'b1, "R4 R8 low load applies staged high");
        end

        // R10: low load with nothing staged keeps high byte
        run_op(3'd2, 8'h42, 8'h00, 1'b0, 1'b0, 1'b1, "R10 keep high without staging");

        // R11: restage overwrites
        run_op(3'd1, 8'h11, 8'h00, 1'b0, 1'b0, 1'b1, "R7 first stage");
        run_op(3'd1, 8'h22, 8'h00, 1'b0, 1'b0, 1'b1, "R11 second stage");
        run_op(3'd2, 8'h33, 8'h00, 1'b0, 1'b0, 1'b1, "R11 latest staged byte applied");

        // R5/R6/R9: all flag pairs, both sources, staged and not
        for (int src = 0; src < 2; src++) begin
            for (int f = 0; f < 4; f++) begin
                for (int s = 0; s < 2; s++) begin
                    if (s == 1) begin
                        run_op(3'd1, 8'(8'hC0 + f), 8'h00, 1'b0, 1'b0, 1'b1, "R7 stage before jump");
                    end
                    run_op(3'(3 + src), 8'(8'h50 + f), 8'(8'hA0 + f), f[1], f[0], 1'b1,
                           "R5 R6 R9 jump decision and source");
                    run_op(3'd2, 8'h08, 8'h00, 1'b0, 1'b0, 1'b1, "R8 R9 pending state after jump");
                end
            end
        end

        // mixed pseudo-random stream against the model
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rop = lfsr[2:0];
            run_op(rop, lfsr[10:3], lfsr[15:8], lfsr[11], lfsr[12], (lfsr[14:13] != 2'b00),
                   "R2 R4 R5 R6 R8 mixed stream");
        end

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: expired=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule